// File: doc/BRIEF.md
# Double-Word Arithmetic Shifter

This block is the shift unit behind a register-pair arithmetic shift instruction. It receives a high word, a low word, a 16-bit count word and a flag that picks between pair mode and odd-register mode. One clock after a valid request it presents the two result words, a two-bit write-enable mask and the four condition flags N, Z, V and C.

In pair mode the 32-bit operand is the high word followed by the low word, and both result halves are meant to be written back. In odd-register mode a single register feeds both halves of the operand, so the shift acts on `{lo_in, lo_in}`, and only the low result half is meant to be written. The flags always describe the full 32-bit result, including the half that is never stored. In odd mode a right shift by 16 therefore hands back the source word unchanged, and the stored word can disagree with N and Z. Register selection happens elsewhere.

Top module: `dword_ash_unit`

## Requirements
- R1: Only bits 5:0 of the count word are used, read as a two's-complement value from -32 to +31; bits 15:6 are ignored. A field of 0 leaves the operand unchanged. The field value 65 acts as +1, 60 acts as -4, and octal 177770 acts as -8.
- R2: A positive count shifts the 32-bit operand left by that many places, with zeros entering at bit 0.
- R3: A negative count shifts the 32-bit operand right by its magnitude, with copies of bit 31 entering at the top. A shift by 32 therefore fills both words with the sign.
- R4: C is the last bit shifted out of the 32-bit operand: bit 32-n for a left shift by n, and bit n-1 for a right shift by n. C is 0 for a zero count.
- R5: V is 1 only for a left shift during which bit 31 takes at least one value that differs from the original bit 31. V is 0 for right shifts and for a zero count.
- R6: N equals bit 31 of the 32-bit result. Z is 1 exactly when all 32 result bits are zero. Both hold in odd mode as well, where the high half is never stored.
- R7: In pair mode (`odd_mode`=0) the operand is `{hi_in, lo_in}` and `wr_mask` is 2'b11. In odd mode (`odd_mode`=1) the operand is `{lo_in, lo_in}`, `hi_in` is ignored, and `wr_mask` is 2'b01. Bit 0 of `wr_mask` enables the low half and bit 1 the high half. `res_hi` always carries the high half of the 32-bit result.
- R8: A request accepted with `in_valid` high at a rising edge shows up on the outputs after that edge, with `out_valid` high for one cycle. In a cycle without a request, `out_valid` is 0 and all other outputs keep their last values.
- R9: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A shift request is presented this cycle |
| hi_in | input | 16 | High operand word (pair mode only) |
| lo_in | input | 16 | Low operand word; sole source in odd mode |
| cnt_in | input | 16 | Count word; bits 5:0 give the signed shift |
| odd_mode | input | 1 | 1 selects odd-register mode, 0 selects pair mode |
| out_valid | output | 1 | Result registered from the previous cycle's request |
| res_hi | output | 16 | High half of the 32-bit result |
| res_lo | output | 16 | Low half of the 32-bit result |
| wr_mask | output | 2 | Write enables: bit 0 low half, bit 1 high half |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag over all 32 bits |
| flag_v | output | 1 | Sign change during a left shift |
| flag_c | output | 1 | Last bit shifted out |

## Verification
Two functions can act in the same cycle. First, one left shift can both carry a set bit out and flip the sign, so V and C are decided by a single count. Second, in odd mode the stored low word and the flags are computed from different halves of one hidden result. The bench provokes both by sweeping all 64 count fields in both modes, with operands whose set bits cross bit 31 and bit 32 at different counts, and by fixed cases such as odd-mode octal 002010 shifted left 13, where the stored word is zero while Z stays 0. Every output is judged on each clock against a reference model that shifts one place at a time and records C and every change of bit 31 along the way.

// File: rtl/ashc_pkg.sv
package ashc_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        SHDIR_HOLD  = 2'd0,
        SHDIR_LEFT  = 2'd1,
        SHDIR_RIGHT = 2'd2
    } shdir_e;

    localparam logic [1:0] WMASK_PAIR = 2'b11;
    localparam logic [1:0] WMASK_ODD  = 2'b01;

endpackage

// File: rtl/ashc_count_decode.sv
module ashc_count_decode
    import ashc_pkg::*;
#(
    parameter int DW = 32,
    parameter int LG = $clog2(DW)
) (
    input  logic [LG:0]   field,
    output shdir_e        dir,
    output logic [LG-1:0] left_amt,
    output logic [LG:0]   right_amt
);

    // The field is a signed value: top bit set means a right shift.
    always_comb begin
        dir       = SHDIR_HOLD;
        left_amt  = '0;
        right_amt = '0;
        if (field == '0) begin
            dir = SHDIR_HOLD;
        end else if (!field[LG]) begin
            dir      = SHDIR_LEFT;
            left_amt = field[LG-1:0];
        end else begin
            dir       = SHDIR_RIGHT;
            right_amt = (~field) + {{LG{1'b0}}, 1'b1};
        end
    end

endmodule

// File: rtl/ashc_shift_core.sv
module ashc_shift_core
    import ashc_pkg::*;
#(
    parameter int DW = 32,
    parameter int LG = $clog2(DW)
) (
    input  logic [DW-1:0] operand,
    input  shdir_e        dir,
    input  logic [LG-1:0] left_amt,
    input  logic [LG:0]   right_amt,
    output logic [DW-1:0] result,
    output logic          carry,
    output logic          ovf
);

    localparam int XW = 2 * DW;

    // Left path: operand sits in the lower half, bits leave into the upper half.
    logic [XW-1:0] lsh [LG+1];
    assign lsh[0] = {{DW{1'b0}}, operand};

    for (genvar k = 0; k < LG; k++) begin : g_lstage
        localparam int STEP = 2 ** k;
        assign lsh[k+1] = left_amt[k] ? (lsh[k] << STEP) : lsh[k];
    end

    // Right path: operand sits in the upper half, bits leave into the lower half.
    logic [XW-1:0] rsh [LG+2];
    assign rsh[0] = {operand, {DW{1'b0}}};

    for (genvar k = 0; k <= LG; k++) begin : g_rstage
        localparam int STEP = 2 ** k;
        assign rsh[k+1] = right_amt[k] ? XW'($signed(rsh[k]) >>> STEP) : rsh[k];
    end

    // Sign-change detection: bit i reaches position DW-1 when amt >= DW-1-i.
    logic [DW-2:0] sign_hit;
    logic [LG:0]   left_amt_x;
    assign left_amt_x = {1'b0, left_amt};

    for (genvar i = 0; i < DW - 1; i++) begin : g_vhit
        localparam logic [LG:0] NEED = (LG+1)'(DW - 1 - i);
        assign sign_hit[i] = (operand[i] != operand[DW-1]) && (left_amt_x >= NEED);
    end

    always_comb begin
        result = operand;
        carry  = 1'b0;
        ovf    = 1'b0;
        unique case (dir)
            SHDIR_LEFT: begin
                result = lsh[LG][DW-1:0];
                carry  = lsh[LG][DW];
                ovf    = |sign_hit;
            end
            SHDIR_RIGHT: begin
                result = rsh[LG+1][XW-1:DW];
                carry  = rsh[LG+1][DW-1];
            end
            default: begin
                result = operand;
            end
        endcase
    end

endmodule

// File: rtl/ashc_flag_gen.sv
module ashc_flag_gen #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] value,
    output logic          neg,
    output logic          zero
);

    always_comb begin
        neg  = value[DW-1];
        zero = (value == '0);
    end

endmodule

// File: rtl/dword_ash_unit.sv
module dword_ash_unit
    import ashc_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] hi_in,
    input  logic [W-1:0] lo_in,
    input  logic [W-1:0] cnt_in,
    input  logic         odd_mode,
    output logic         out_valid,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo,
    output logic [1:0]   wr_mask,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_v,
    output logic         flag_c
);

    localparam int DW = 2 * W;
    localparam int LG = $clog2(DW);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        logic [1:0]   mask;
        logic         n;
        logic         z;
        logic         v;
        logic         c;
    } stage_t;

    stage_t st_d, st_q;

    logic [DW-1:0] operand_d;
    shdir_e        dir_d;
    logic [LG-1:0] left_amt_d;
    logic [LG:0]   right_amt_d;
    logic [DW-1:0] shifted_d;
    logic          carry_d;
    logic          ovf_d;
    logic          neg_d;
    logic          zero_d;

    // Odd mode feeds the same word into both halves.
    assign operand_d = odd_mode ? {lo_in, lo_in} : {hi_in, lo_in};

    ashc_count_decode #(
        .DW (DW),
        .LG (LG)
    ) i_decode (
        .field     (cnt_in[LG:0]),
        .dir       (dir_d),
        .left_amt  (left_amt_d),
        .right_amt (right_amt_d)
    );

    ashc_shift_core #(
        .DW (DW),
        .LG (LG)
    ) i_core (
        .operand   (operand_d),
        .dir       (dir_d),
        .left_amt  (left_amt_d),
        .right_amt (right_amt_d),
        .result    (shifted_d),
        .carry     (carry_d),
        .ovf       (ovf_d)
    );

    ashc_flag_gen #(
        .DW (DW)
    ) i_flags (
        .value (shifted_d),
        .neg   (neg_d),
        .zero  (zero_d)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.hi   = shifted_d[DW-1:W];
            st_d.lo   = shifted_d[W-1:0];
            st_d.mask = odd_mode ? WMASK_ODD : WMASK_PAIR;
            st_d.n    = neg_d;
            st_d.z    = zero_d;
            st_d.v    = ovf_d;
            st_d.c    = carry_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign res_hi    = st_q.hi;
    assign res_lo    = st_q.lo;
    assign wr_mask   = st_q.mask;
    assign flag_n    = st_q.n;
    assign flag_z    = st_q.z;
    assign flag_v    = st_q.v;
    assign flag_c    = st_q.c;

endmodule

// File: rtl/ashc_checker.sv
module ashc_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] hi_in,
    input logic [W-1:0] lo_in,
    input logic [W-1:0] cnt_in,
    input logic         odd_mode,
    input logic         out_valid,
    input logic [W-1:0] res_hi,
    input logic [W-1:0] res_lo,
    input logic [1:0]   wr_mask,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_v,
    input logic         flag_c
);

    localparam int CB = $clog2(2 * W);

    AST_ODD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && odd_mode) |=> (wr_mask == 2'b01)); // R7

    AST_PAIR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !odd_mode) |=> (wr_mask == 2'b11)); // R7

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res_hi) && $stable(res_lo) && $stable(wr_mask))); // R8

    AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !odd_mode && cnt_in[CB:0] == '0)
        |=> (res_hi == $past(hi_in) && res_lo == $past(lo_in) && !flag_c && !flag_v)); // R1

    AST_RIGHT_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_in[CB]) |=> !flag_v); // R5

    AST_NEG_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_n == res_hi[W-1])); // R6

    AST_ZERO_ALL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_z == ({res_hi, res_lo} == '0))); // R6

    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (!out_valid && wr_mask == 2'b00 && res_hi == '0 && res_lo == '0); // R9
        end
    end

endmodule

bind dword_ash_unit ashc_checker #(.W(W)) i_ashc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .hi_in     (hi_in),
    .lo_in     (lo_in),
    .cnt_in    (cnt_in),
    .odd_mode  (odd_mode),
    .out_valid (out_valid),
    .res_hi    (res_hi),
    .res_lo    (res_lo),
    .wr_mask   (wr_mask),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_v    (flag_v),
    .flag_c    (flag_c)
);

// File: tb/test_dword_ash_unit.sv
module test_dword_ash_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] hi_in = '0;
    logic [15:0] lo_in = '0;
    logic [15:0] cnt_in = '0;
    logic        odd_mode = 1'b0;
    logic        out_valid;
    logic [15:0] res_hi;
    logic [15:0] res_lo;
    logic [1:0]  wr_mask;
    logic        flag_n;
    logic        flag_z;
    logic        flag_v;
    logic        flag_c;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit run_chk = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dword_ash_unit i_dword_ash_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .hi_in     (hi_in),
        .lo_in     (lo_in),
        .cnt_in    (cnt_in),
        .odd_mode  (odd_mode),
        .out_valid (out_valid),
        .res_hi    (res_hi),
        .res_lo    (res_lo),
        .wr_mask   (wr_mask),
        .flag_n    (flag_n),
        .flag_z    (flag_z),
        .flag_v    (flag_v),
        .flag_c    (flag_c)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural model: one place per step, tracking C and sign changes.
    task automatic ref_shift(input logic [15:0] h, input logic [15:0] l,
                             input logic [15:0] c, input logic odd,
                             output logic [15:0] rh, output logic [15:0] rl,
                             output logic n, output logic z,
                             output logic v, output logic cy);
        logic [31:0] val;
        int sc;
        val = odd ? {l, l} : {h, l};
        sc  = int'(c[5:0]);
        if (sc >= 32) sc = sc - 64;
        cy = 1'b0;
        v  = 1'b0;
        if (sc > 0) begin
            for (int s = 0; s < sc; s++) begin
                logic prev;
                prev = val[31];
                cy   = val[31];
                val  = {val[30:0], 1'b0};
                if (val[31] != prev) v = 1'b1;
            end
        end else if (sc < 0) begin
            for (int s = 0; s < -sc; s++) begin
                cy  = val[0];
                val = {val[31], val[31:1]};
            end
        end
        rh = val[31:16];
        rl = val[15:0];
        n  = val[31];
        z  = (val == 32'd0);
    endtask

    logic        e_valid;
    logic [15:0] e_hi, e_lo;
    logic [1:0]  e_mask;
    logic        e_n, e_z, e_v, e_c;
    string       e_rtag = "R1";

    always @(posedge clk or negedge rst_n) begin : ref_model
        logic [15:0] th, tl;
        logic tn, tz, tv, tc;
        if (!rst_n) begin
            e_valid <= 1'b0;
            e_hi    <= '0;
            e_lo    <= '0;
            e_mask  <= '0;
            e_n     <= 1'b0;
            e_z     <= 1'b0;
            e_v     <= 1'b0;
            e_c     <= 1'b0;
        end else begin
            e_valid <= in_valid;
            if (in_valid) begin
                ref_shift(hi_in, lo_in, cnt_in, odd_mode, th, tl, tn, tz, tv, tc);
                e_hi   <= th;
                e_lo   <= tl;
                e_n    <= tn;
                e_z    <= tz;
                e_v    <= tv;
                e_c    <= tc;
                e_mask <= odd_mode ? 2'b01 : 2'b11;
                if (cnt_in[5:0] == 6'd0)  e_rtag <= "R1";
                else if (!cnt_in[5])      e_rtag <= "R2";
                else                      e_rtag <= "R3";
            end
        end
    end

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n && run_chk) begin
            chk("R8", "out_valid", {31'd0, out_valid}, {31'd0, e_valid});
            chk(e_rtag, "result", {res_hi, res_lo}, {e_hi, e_lo});
            chk("R4", "flag_c", {31'd0, flag_c}, {31'd0, e_c});
            chk("R5", "flag_v", {31'd0, flag_v}, {31'd0, e_v});
            chk("R6", "flag_nz", {30'd0, flag_n, flag_z}, {30'd0, e_n, e_z});
            chk("R7", "wr_mask", {30'd0, wr_mask}, {30'd0, e_mask});
        end
    end

    task automatic drive(input logic [15:0] h, input logic [15:0] l,
                         input logic [15:0] c, input logic odd);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        hi_in    = h;
        lo_in    = l;
        cnt_in   = c;
        odd_mode = odd;
    endtask

    task automatic go_idle();
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        hi_in    = 16'hDEAD;
        lo_in    = 16'hBEEF;
        cnt_in   = 16'h0015;
    endtask

    // Fixed case with constant expectations, sampled just before the next edge.
    task automatic fixed(input string tag, input logic [15:0] h, input logic [15:0] l,
                         input logic [15:0] c, input logic odd,
                         input logic [15:0] eh, input logic [15:0] el,
                         input logic en, input logic ez, input logic ev, input logic ec);
        drive(h, l, c, odd);
        go_idle();
        #3;
        chk(tag, "fixed result", {res_hi, res_lo}, {eh, el});
        chk(tag, "fixed nzvc", {28'd0, flag_n, flag_z, flag_v, flag_c}, {28'd0, en, ez, ev, ec});
        chk(tag, "fixed mask", {30'd0, wr_mask}, {30'd0, (odd ? 2'b01 : 2'b11)});
    endtask

    initial begin : main
        repeat (3) @(posedge clk);
        #2;
        // R9: reset clears every output
        chk("R9", "reset outputs",
            {out_valid, flag_n, flag_z, flag_v, flag_c, wr_mask, res_hi[8:0], res_lo},
            32'd0);
        @(posedge clk);
        #1;
        rst_n   = 1'b1;
        run_chk = 1'b1;

        // R5: left 11 on a pair sets N and V
        fixed("R5", 16'o000020, 16'o000200, 16'd11, 1'b0, 16'o100004, 16'o000000, 1'b1, 1'b0, 1'b1, 1'b0);
        // R4: left 25 clears everything with Z, V, C
        fixed("R4", 16'o000020, 16'o000200, 16'd25, 1'b0, 16'o000000, 16'o000000, 1'b0, 1'b1, 1'b1, 1'b1);
        // R7: odd mode right 16 gives the source back
        fixed("R7", 16'o000000, 16'o002010, 16'hFFF0, 1'b1, 16'o000000, 16'o002010, 1'b0, 1'b0, 1'b0, 1'b0);
        // R7: odd mode right 4, N from the hidden half
        fixed("R7", 16'o000000, 16'o002010, 16'hFFFC, 1'b1, 16'o000100, 16'o100100, 1'b0, 1'b0, 1'b0, 1'b1);
        // R6: odd mode left 13, stored word zero but Z stays 0
        fixed("R6", 16'o000000, 16'o002010, 16'd13, 1'b1, 16'o000201, 16'o000000, 1'b0, 1'b0, 1'b1, 1'b1);
        // R3: negative pair right 32, all ones with C=1
        fixed("R3", 16'o100020, 16'o000200, 16'hFFE0, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1);
        // R3: right 31, all ones with C=0
        fixed("R3", 16'o100020, 16'o000200, 16'hFFE1, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0);
        // R1: field 65 acts as +1
        fixed("R1", 16'o000020, 16'o000200, 16'd65, 1'b0, 16'o000040, 16'o000400, 1'b0, 1'b0, 1'b0, 1'b0);
        // R1: field 60 acts as -4
        fixed("R1", 16'o000020, 16'o000200, 16'd60, 1'b0, 16'o000001, 16'o000010, 1'b0, 1'b0, 1'b0, 1'b0);
        // R1: upper count bits ignored, 177770 acts as -8
        fixed("R1", 16'o000020, 16'o000200, 16'o177770, 1'b0, 16'o000000, 16'o010000, 1'b0, 1'b0, 1'b0, 1'b1);
        // R2: left 8 with zero fill into the low word
        fixed("R2", 16'o000020, 16'o000200, 16'd8, 1'b0, 16'o010000, 16'o100000, 1'b0, 1'b0, 1'b0, 1'b0);
        // R6: zero operand, zero count sets Z
        fixed("R6", 16'o000000, 16'o000000, 16'd0, 1'b0, 16'o000000, 16'o000000, 1'b0, 1'b1, 1'b0, 1'b0);
        // R7: hi_in ignored in odd mode
        fixed("R7", 16'hFFFF, 16'o002010, 16'd0, 1'b1, 16'o002010, 16'o002010, 1'b0, 1'b0, 1'b0, 1'b0);

        // Sweep of every count field in both modes, compared by the model each clock.
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 64; k++) begin
                for (int p = 0; p < 3; p++) begin
                    logic [15:0] h, l;
                    logic [9:0]  up;
                    case (p)
                        0:       begin h = 16'o000020; l = 16'o000200; end
                        1:       begin h = 16'o100020; l = 16'o000200; end
                        default: begin h = 16'hA5C3;   l = 16'h3C5A;   end
                    endcase
                    up = 10'((k * 37 + p * 113 + m * 7) & 10'h3FF);
                    drive(h, l, {up, 6'(k)}, m[0]);
                    if (((k + p) % 5) == 0) go_idle();
                end
            end
        end
        go_idle();
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R8 actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule